// File: doc/BRIEF.md
# Instruction Fetch Address Patch Unit

This unit sits between the internal program ROM and the instruction fetch port of a small CPU. Software loads up to two 24-bit break addresses, one per channel, and turns each channel on with its own enable bit. When the CPU fetches the byte at an enabled break address inside the internal ROM window, the unit returns a fixed one-byte software-interrupt opcode (0x01) instead of the ROM byte. The CPU then traps, and a handler can run patch code in place of the faulty instruction. Fetches outside the window are never altered.

The substitution path is purely combinational, so the fetch takes no extra cycle. Each channel also keeps a sticky match flag, which software clears by writing 1 to it. An interrupt request output is high while any enabled channel has its flag set. The break address must be the first byte of an instruction. If it points into an operand, that operand byte reads as 0x01 and no trap follows. A channel must be disabled before its address bytes are rewritten.

The fetch channel uses a valid/ready handshake that the unit does not throttle. `fch_valid` comes from the requester and `fch_ready` from the consumer, and both are observed only. While a fetch is stalled (valid high, ready low), the substituted byte stays on `fch_rdata`, but a flag is set only on the cycle in which the transfer completes.

Top module: `ifp_patch_unit`

## Requirements
- R1: After reset, all six address bytes read 0, both enables and both flags read 0, and `irq` is low.
- R2: Config offsets 0, 1 and 2 hold the low, middle and high bytes of channel 0's address. Offsets 3, 4 and 5 hold the same bytes for channel 1. Each offset is written by `cfg_we` and reads back on `cfg_rdata`.
- R3: Config offset 6 is the control byte. Bit 0 and bit 1 are the enables of channel 0 and channel 1, and a write stores them. Bit 4 and bit 5 read as the match flags of channel 0 and channel 1. All other bits read 0, and offset 7 reads 0.
- R4: When `fch_valid` is high and `fch_addr` equals an enabled channel's address inside the ROM window, `fch_rdata` is 0x01 and `patch_hit` is high in that same cycle. A neighbouring address is not substituted.
- R5: A channel whose enable bit is 0 never substitutes data and never sets its flag.
- R6: An address outside the window [ROM_BASE, ROM_LIMIT] (default 0xFF0000 to 0xFFFFFF) never substitutes, even when it is programmed and enabled.
- R7: With `fch_valid` low, `fch_rdata` equals `rom_rdata` and `patch_hit` is low.
- R8: A channel's flag is set at the clock edge that ends an accepted matching fetch and stays set. Writing control with that flag's bit at 1 clears it, and writing 0 to that bit leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: `irq` is high exactly when some channel has both its flag and its enable set.
- R10: If both channels match the same fetch, the data is substituted once (0x01) and both flags are set.
- R11: A matching fetch with `fch_ready` low is substituted but sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config byte offset, used for both write and read |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data (combinational on `cfg_addr`) |
| fch_valid | input | 1 | Fetch address valid |
| fch_ready | input | 1 | Fetch consumer accepts this cycle |
| fch_addr | input | 24 | Fetch byte address |
| rom_rdata | input | 8 | Byte from the program ROM |
| fch_rdata | output | 8 | Byte delivered to the CPU |
| patch_hit | output | 1 | Substitution happening this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- any hit delivers the opcode and lies inside the ROM window;
- an idle fetch port passes the ROM byte straight through;
- a flag rises only after an accepted fetch on an enabled channel;
- a flag stays set unless it was cleared.

Only the bench scenarios can show the rest:
- the byte ordering of the address registers;
- an exact address hit against its neighbours;
- the set-beats-clear collision;
- a dual-channel hit;
- `irq` following the enables while flags stay pending;
- read-back of the control byte.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned FLAG_LSB = 4;
  localparam logic [BYTE_W-1:0] SWI_OPCODE = 8'h01;

  function automatic int unsigned bytes_for(input int unsigned width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/ifp_regs.sv
module ifp_regs
  import ifp_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CFG_AW = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [BYTE_W-1:0]              cfg_wdata,
  output logic [BYTE_W-1:0]              cfg_rdata,
  input  logic [NUM_CH-1:0]              acc_hit,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  det_addr,
  output logic [NUM_CH-1:0]              ch_en,
  output logic [NUM_CH-1:0]              ch_flag
);
  localparam int unsigned NB     = bytes_for(ADDR_W);
  localparam int unsigned NBYTES = NB * NUM_CH;
  localparam int unsigned CTL    = NBYTES;

  logic [NBYTES*BYTE_W-1:0] bytes_q;
  logic [NUM_CH-1:0]        en_q, flag_q, clr;
  logic                     ctl_wr;

  assign ctl_wr = cfg_we && (cfg_addr == CFG_AW'(CTL));
  assign clr    = ctl_wr ? cfg_wdata[FLAG_LSB +: NUM_CH] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NBYTES; k++) begin
        if (cfg_addr == CFG_AW'(k)) bytes_q[k*BYTE_W +: BYTE_W] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ctl_wr) en_q <= cfg_wdata[NUM_CH-1:0];
      flag_q <= (flag_q & ~clr) | acc_hit;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
      assign det_addr[c] = bytes_q[c*NB*BYTE_W +: ADDR_W];

      // R5: a flag only rises after an accepted hit on an enabled channel
      a_r5_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[c]) |-> $past(en_q[c]));
      // R8: a flag holds unless a clear was written
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q[c]) && !$past(clr[c])) |-> flag_q[c]);
      // R8: a clear without a simultaneous hit drops the flag
      a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr[c]) && !$past(acc_hit[c])) |-> !flag_q[c]);
    end
  endgenerate

  assign ch_en   = en_q;
  assign ch_flag = flag_q;

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (cfg_addr == CFG_AW'(k)) cfg_rdata = bytes_q[k*BYTE_W +: BYTE_W];
    end
    if (cfg_addr == CFG_AW'(CTL)) begin
      cfg_rdata[NUM_CH-1:0]          = en_q;
      cfg_rdata[FLAG_LSB +: NUM_CH]  = flag_q;
    end
  end
endmodule

// File: rtl/ifp_cmp.sv
module ifp_cmp #(
  parameter int unsigned          ADDR_W    = 24,
  parameter logic [ADDR_W-1:0]    ROM_BASE  = 'hFF0000,
  parameter logic [ADDR_W-1:0]    ROM_LIMIT = 'hFFFFFF
) (
  input  logic              fch_valid,
  input  logic [ADDR_W-1:0] fch_addr,
  input  logic [ADDR_W-1:0] det_addr,
  input  logic              en,
  output logic              hit
);
  logic in_win, eq;
  assign in_win = (fch_addr >= ROM_BASE) && (fch_addr <= ROM_LIMIT);
  assign eq     = (fch_addr == det_addr);
  assign hit    = fch_valid && en && eq && in_win;
endmodule

// File: rtl/ifp_subst.sv
module ifp_subst
  import ifp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPCODE = SWI_OPCODE
) (
  input  logic              any_hit,
  input  logic [BYTE_W-1:0] rom_rdata,
  output logic [BYTE_W-1:0] fch_rdata
);
  assign fch_rdata = any_hit ? OPCODE : rom_rdata;
endmodule

// File: rtl/ifp_patch_unit.sv
module ifp_patch_unit
  import ifp_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       NUM_CH    = 2,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 'hFF0000,
  parameter logic [ADDR_W-1:0] ROM_LIMIT = 'hFFFFFF,
  localparam int unsigned      CFG_AW    = $clog2(bytes_for(ADDR_W) * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              fch_valid,
  input  logic              fch_ready,
  input  logic [ADDR_W-1:0] fch_addr,
  input  logic [7:0]        rom_rdata,
  output logic [7:0]        fch_rdata,
  output logic              patch_hit,
  output logic              irq
);
  logic [NUM_CH-1:0][ADDR_W-1:0] det_addr;
  logic [NUM_CH-1:0]             ch_en, ch_flag, hit_vec, acc_hit;

  ifp_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_hit(acc_hit),
    .det_addr(det_addr), .ch_en(ch_en), .ch_flag(ch_flag)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ifp_cmp #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_LIMIT(ROM_LIMIT)) u_cmp (
        .fch_valid(fch_valid), .fch_addr(fch_addr), .det_addr(det_addr[c]),
        .en(ch_en[c]), .hit(hit_vec[c])
      );
      // R11: a flag only rises after a completed handshake
      a_r11_flag_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_flag[c]) |-> ($past(fch_ready) && $past(fch_valid)));
    end
  endgenerate

  assign acc_hit   = hit_vec & {NUM_CH{fch_ready}};
  assign patch_hit = |hit_vec;
  assign irq       = |(ch_flag & ch_en);

  ifp_subst u_subst (.any_hit(patch_hit), .rom_rdata(rom_rdata), .fch_rdata(fch_rdata));

  // R4: any hit delivers the interrupt opcode
  a_r4_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hit |-> (fch_rdata == SWI_OPCODE));
  // R6: hits only inside the ROM window
  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hit |-> ((fch_addr >= ROM_BASE) && (fch_addr <= ROM_LIMIT)));
  // R7: idle fetch port passes ROM data through
  a_r7_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !fch_valid |-> (!patch_hit && (fch_rdata == rom_rdata)));
endmodule

// File: tb/sim_ifp_patch_unit.sv
`timescale 1ns/1ps
module sim_ifp_patch_unit;
  localparam logic [23:0] BASE  = 24'hFF0000;
  localparam logic [23:0] LIMIT = 24'hFFFFFF;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, fch_valid = 0, fch_ready = 0;
  logic [2:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, rom_rdata = 0;
  logic [23:0] fch_addr = 0;
  logic [7:0] cfg_rdata, fch_rdata;
  logic patch_hit, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [23:0] m_addr [2];
  logic [1:0]  m_en, m_flag;

  always #5 clk = ~clk;

  ifp_patch_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fch_valid(fch_valid),
    .fch_ready(fch_ready), .fch_addr(fch_addr), .rom_rdata(rom_rdata),
    .fch_rdata(fch_rdata), .patch_hit(patch_hit), .irq(irq)
  );

  function automatic logic [1:0] exp_hits(logic v, logic [23:0] a);
    logic [1:0] h;
    for (int c = 0; c < 2; c++)
      h[c] = v && m_en[c] && (a == m_addr[c]) && (a >= BASE) && (a <= LIMIT);
    return h;
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_addr[0][7:0];
      3'd1: return m_addr[0][15:8];
      3'd2: return m_addr[0][23:16];
      3'd3: return m_addr[1][7:0];
      3'd4: return m_addr[1][15:8];
      3'd5: return m_addr[1][23:16];
      3'd6: return {2'b00, m_flag, 2'b00, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, advance model at posedge
  task automatic cyc(logic we, logic [2:0] ca, logic [7:0] wd, logic v, logic rdy,
                     logic [23:0] fa, logic [7:0] rd, string req);
    logic [1:0] h, clr;
    logic [7:0] ed;
    cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
    fch_valid = v; fch_ready = rdy; fch_addr = fa; rom_rdata = rd;
    #1;
    h  = exp_hits(v, fa);
    ed = (|h) ? 8'h01 : rd;
    chk(fch_rdata == ed, req, fch_rdata, ed);
    chk(patch_hit == |h, req, patch_hit, |h);
    chk(irq == |(m_flag & m_en), {req, "/R9"}, irq, |(m_flag & m_en));
    if (!we) chk(cfg_rdata == exp_rd(ca), {req, "/R3"}, cfg_rdata, exp_rd(ca));
    @(posedge clk);
    clr = (we && ca == 3'd6) ? wd[5:4] : 2'b00;
    if (we) begin
      case (ca)
        3'd0: m_addr[0][7:0]   = wd;
        3'd1: m_addr[0][15:8]  = wd;
        3'd2: m_addr[0][23:16] = wd;
        3'd3: m_addr[1][7:0]   = wd;
        3'd4: m_addr[1][15:8]  = wd;
        3'd5: m_addr[1][23:16] = wd;
        3'd6: m_en = wd[1:0];
        default: ;
      endcase
    end
    m_flag = (m_flag & ~clr) | (h & {2{rdy}});
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string req);
    cyc(1, a, d, 0, 0, 24'h0, 8'h5A, req);
  endtask
  task automatic rd(logic [2:0] a, string req);
    cyc(0, a, 8'h00, 0, 0, 24'h0, 8'h33, req);
  endtask
  task automatic fetch(logic [23:0] a, logic rdy, logic [7:0] d, string req);
    cyc(0, 3'd6, 8'h00, 1, rdy, a, d, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    m_addr[0] = 0; m_addr[1] = 0; m_en = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset values of every register
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    // R2: byte ordering, channel 0 = FF001F
    wr(0, 8'h1F, "R2"); wr(1, 8'h00, "R2"); wr(2, 8'hFF, "R2");
    for (int a = 0; a < 3; a++) rd(3'(a), "R2");
    // R5: disabled channel ignored
    fetch(24'hFF001F, 1, 8'hA8, "R5");
    rd(3'd6, "R5");
    // R3: enable channel 0
    wr(6, 8'h01, "R3"); rd(3'd6, "R3");
    // R4: exact hit and neighbours
    fetch(24'hFF001E, 1, 8'h4A, "R4");
    fetch(24'hFF001F, 1, 8'hA8, "R4");
    fetch(24'hFF0020, 1, 8'h00, "R4");
    rd(3'd6, "R4");
    // R7: idle port passes ROM byte
    cyc(0, 3'd6, 0, 0, 1, 24'hFF001F, 8'hC3, "R7");
    // R8: writing 0 to flag keeps it, writing 1 clears it
    wr(6, 8'h01, "R8"); rd(3'd6, "R8");
    wr(6, 8'h11, "R8"); rd(3'd6, "R8");
    // R11: stalled hit substitutes but sets no flag
    fetch(24'hFF001F, 0, 8'h77, "R11"); rd(3'd6, "R11");
    // R8: set wins over clear in the same cycle
    cyc(1, 3'd6, 8'h11, 1, 1, 24'hFF001F, 8'h77, "R8");
    rd(3'd6, "R8");
    // R6: channel 1 outside window, enabled
    wr(3, 8'h34, "R6"); wr(4, 8'h12, "R6"); wr(5, 8'h00, "R6");
    wr(6, 8'h03, "R6");
    fetch(24'h001234, 1, 8'h99, "R6"); rd(3'd6, "R6");
    // R10: both channels on the same address
    wr(6, 8'h00, "R10");
    wr(3, 8'h1F, "R10"); wr(4, 8'h00, "R10"); wr(5, 8'hFF, "R10");
    wr(6, 8'h33, "R10");
    fetch(24'hFF001F, 1, 8'hA8, "R10"); rd(3'd6, "R10");
    // R9: irq follows enables while flags pending
    wr(6, 8'h00, "R9"); rd(3'd6, "R9");
    wr(6, 8'h02, "R9"); rd(3'd6, "R9");
    wr(6, 8'h30, "R9"); rd(3'd6, "R9");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 10;
      logic [23:0] fa;
      case ($urandom % 4)
        0: fa = m_addr[0];
        1: fa = m_addr[1];
        2: fa = BASE | 24'($urandom % 64);
        default: fa = 24'($urandom);
      endcase
      if (r < 2)
        cyc(1, 3'($urandom % 7), 8'($urandom) | 8'h00, 1'($urandom), 1'($urandom), fa, 8'($urandom), "R4/R8 rand");
      else if (r < 3)
        cyc(1, 3'd6, 8'($urandom), 1'($urandom), 1'($urandom), fa, 8'($urandom), "R3/R8 rand");
      else
        cyc(0, 3'($urandom), 8'h00, 1'($urandom), 1'($urandom), fa, 8'($urandom), "R4/R11 rand");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule